// File: doc/BRIEF.md
# Gated Status/Control Register Bank

This block holds the host-visible registers of a power-management controller. It sits behind a single-cycle host bus with an address, write data, a write strobe, a read strobe and combinational read data. Eight core registers sit in the low address range: live status, alert mask, control, switch control, two fault logs, GPIO and ADC channel select. These eight repeat once above themselves. Thirteen ADC measurement registers fill the upper half of the decoded space.

Some registers mix read-only status bits with host-writable bits. Some bits are write-protected while a live status input holds. The measurement registers refuse host writes unless an unlock bit in the control register is set. A separate internal port lets the ADC load measurements at any time, and this port wins over the host.

Top module: `pm_regbank`

## Requirements
- R1: Host address bits 7:5 are ignored. Only bits 4:0 select a register.
- R2: The core registers at offsets 0x00 to 0x07 (0x00 status, 0x01 alert mask, 0x02 control, 0x03 switch, 0x04 fault log A, 0x05 fault log B, 0x06 GPIO, 0x07 ADC channel) also answer at offsets 0x08 to 0x0F.
- R3: Offsets 0x10 to 0x1B each select a separate measurement register. Offsets 0x1C to 0x1F all select one shared thirteenth register.
- R4: A host write to a measurement register takes effect only while control bit 7 is 1. Otherwise the register keeps its value.
- R5: The status register is read-only. A read returns the live status input with this bit meaning: 7 ADC busy, 6 board select, 5 FET short, 4 local reset output, 3 reset input, 2 power bad, 1 soft-start busy, 0 undervoltage. A write to it changes no register.
- R6: In the switch register, bits 3:0 are host-writable. Bits 7:4 read the live switch status input.
- R7: While status bit 1 (soft-start busy) is 1, a write cannot move any switch bit 3:0 from 0 to 1. Such a write can still clear these bits, bit by bit.
- R8: In the GPIO register, bits 2:0 read the live pin input and are read-only. Bits 7:3 are host-writable.
- R9: The ADC channel register stores a 4-bit field in bits 3:0. Bits 7:4 read 0.
- R10: After reset, every writable bit reads 0.
- R11: The internal ADC port (select values 0 to 12) loads a measurement register whatever the value of control bit 7. When the host writes the same register in the same cycle, the ADC value is kept.
- R12: Read data is combinational in the cycle of the read. It is 0 when the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data |
| stat_in | input | 8 | Live status bits |
| sw_stat | input | 4 | Live switch status, read as switch bits 7:4 |
| gpio_pins | input | 3 | Live GPIO pin levels |
| adc_we | input | 1 | Internal ADC load strobe |
| adc_sel | input | 4 | Measurement register index for the ADC load |
| adc_wdata | input | 8 | Measurement value from the ADC |

## Verification
The bench builds the block with its default parameters: an 8-bit host address, 8-bit data and thirteen measurement registers. These values make every case reachable. The three ignored address bits are exercised. Both the mirrored core range and the four aliases of the shared measurement register are read. The last separate measurement index and the shared one can both be hit from the ADC port and from the host.

// File: rtl/pm_regbank.sv
module pm_regbank #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NM = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_we,
  input  logic          host_re,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] stat_in,
  input  logic [3:0]    sw_stat,
  input  logic [2:0]    gpio_pins,
  input  logic          adc_we,
  input  logic [3:0]    adc_sel,
  input  logic [DW-1:0] adc_wdata
);
  localparam int DEC = 5;
  localparam logic [3:0] LAST = 4'(NM - 1);

  logic [DW-1:0] alert_q, ctrl_q, flt_a_q, flt_b_q;
  logic [3:0]    sw_q, ch_q;
  logic [4:0]    gp_q;
  logic [NM-1:0][DW-1:0] meas_q;

  logic [DEC-1:0] a5;
  logic           is_meas, ss_busy, unlock, adc_ok;
  logic [3:0]     midx, sw_next;

  assign a5      = host_addr[DEC-1:0];
  assign is_meas = a5[4];
  assign midx    = (a5[3:0] > LAST) ? LAST : a5[3:0];
  assign ss_busy = stat_in[1];
  assign unlock  = ctrl_q[7];
  assign adc_ok  = adc_we && (adc_sel <= LAST);
  assign sw_next = ss_busy ? (host_wdata[3:0] & sw_q) : host_wdata[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert_q <= '0;
      ctrl_q  <= '0;
      flt_a_q <= '0;
      flt_b_q <= '0;
      sw_q    <= '0;
      ch_q    <= '0;
      gp_q    <= '0;
    end else if (host_we && !is_meas) begin
      case (a5[2:0])
        3'd1: alert_q <= host_wdata;
        3'd2: ctrl_q  <= host_wdata;
        3'd3: sw_q    <= sw_next;
        3'd4: flt_a_q <= host_wdata;
        3'd5: flt_b_q <= host_wdata;
        3'd6: gp_q    <= host_wdata[7:3];
        3'd7: ch_q    <= host_wdata[3:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_meas
    always_ff @(posedge clk) begin
      if (!rst_n)
        meas_q[i] <= '0;
      else if (adc_ok && adc_sel == 4'(i))
        meas_q[i] <= adc_wdata;
      else if (host_we && is_meas && unlock && midx == 4'(i))
        meas_q[i] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_re) begin
      if (is_meas)
        host_rdata = meas_q[midx];
      else
        case (a5[2:0])
          3'd0: host_rdata = stat_in;
          3'd1: host_rdata = alert_q;
          3'd2: host_rdata = ctrl_q;
          3'd3: host_rdata = {sw_stat, sw_q};
          3'd4: host_rdata = flt_a_q;
          3'd5: host_rdata = flt_b_q;
          3'd6: host_rdata = {gp_q, gpio_pins};
          default: host_rdata = {4'b0, ch_q};
        endcase
    end
  end

  // R4: locked host write leaves measurements alone
  a_r4_meas_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && is_meas && !unlock && !adc_we) |=> $stable(meas_q));

  // R5: status write touches no stored register
  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !is_meas && a5[2:0] == 3'd0) |=>
      $stable({alert_q, ctrl_q, flt_a_q, flt_b_q, sw_q, ch_q, gp_q}));

  // R7: no rising switch bit while soft-start busy
  a_r7_ss_block: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !is_meas && a5[2:0] == 3'd3 && ss_busy) |=>
      ((sw_q & ~$past(sw_q)) == 4'b0));

  // R11: ADC load always lands
  a_r11_adc_prio: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ok |=> (meas_q[$past(adc_sel)] == $past(adc_wdata)));

  // R12: idle read bus
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |-> host_rdata == '0);
endmodule

// File: tb/tb_pm_regbank.sv
module tb_pm_regbank;
  logic clk = 0, rst_n = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic host_we = 0, host_re = 0;
  logic [7:0] stat_in = 0;
  logic [3:0] sw_stat = 0;
  logic [2:0] gpio_pins = 0;
  logic adc_we = 0;
  logic [3:0] adc_sel = 0;
  logic [7:0] adc_wdata = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_regbank dut (.*);

  // {is_read, req, addr, data/expected}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd2,  8'h02, 8'h80},
    {1'b1, 4'd2,  8'h0A, 8'h80},   // R2 mirror
    {1'b1, 4'd1,  8'hE2, 8'h80},   // R1 high bits ignored
    {1'b0, 4'd4,  8'h11, 8'h5A},
    {1'b1, 4'd4,  8'h11, 8'h5A},   // R4 unlocked
    {1'b1, 4'd1,  8'h31, 8'h5A},   // R1
    {1'b0, 4'd3,  8'h1C, 8'h33},
    {1'b1, 4'd3,  8'h1F, 8'h33},   // R3 shared alias
    {1'b1, 4'd3,  8'h1B, 8'h00},   // R3 separate
    {1'b0, 4'd3,  8'h1B, 8'h44},
    {1'b1, 4'd3,  8'h1D, 8'h33},   // R3 shared untouched
    {1'b0, 4'd6,  8'h0B, 8'h0F},
    {1'b1, 4'd6,  8'h03, 8'h0F},   // R6
    {1'b0, 4'd8,  8'h0E, 8'hFF},
    {1'b1, 4'd8,  8'h06, 8'hF8},   // R8
    {1'b0, 4'd9,  8'h07, 8'hFF},
    {1'b1, 4'd9,  8'h0F, 8'h0F},   // R9
    {1'b0, 4'd2,  8'h09, 8'hA5},
    {1'b1, 4'd2,  8'h01, 8'hA5},
    {1'b1, 4'd2,  8'h0D, 8'h00}
  };

  task automatic chk(input logic [7:0] act, exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, exp, input string req);
    @(negedge clk); host_addr = a; host_re = 1; #1;
    chk(host_rdata, exp, req);
    host_re = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values
    rd(8'h01, 8'h00, "R10"); rd(8'h02, 8'h00, "R10");
    rd(8'h03, 8'h00, "R10"); rd(8'h10, 8'h00, "R10");
    rd(8'h1E, 8'h00, "R10");
    // R12 idle bus
    @(negedge clk); host_addr = 8'h00; stat_in = 8'hFF; #1;
    chk(host_rdata, 8'h00, "R12"); stat_in = 0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rd(VEC[i][15:8], VEC[i][7:0], $sformatf("R%0d", VEC[i][19:16]));
      else wr(VEC[i][15:8], VEC[i][7:0]);
    end

    // R4 locked write dropped
    wr(8'h02, 8'h00);
    wr(8'h12, 8'h77);
    rd(8'h12, 8'h00, "R4");
    rd(8'h11, 8'h5A, "R4");
    // R5 live status and read-only
    stat_in = 8'hA4;
    rd(8'h00, 8'hA4, "R5");
    wr(8'h08, 8'hFF);
    rd(8'h08, 8'hA4, "R5");
    rd(8'h01, 8'hA5, "R5");
    rd(8'h02, 8'h00, "R5");
    stat_in = 8'h00;
    // R7 soft-start masking (switch currently 0F)
    wr(8'h03, 8'h00); stat_in = 8'h02;
    wr(8'h03, 8'h05);
    rd(8'h03, 8'h00, "R7");
    stat_in = 8'h00; wr(8'h03, 8'h0F); stat_in = 8'h02;
    wr(8'h03, 8'h05);
    rd(8'h03, 8'h05, "R7");
    wr(8'h03, 8'h0B);
    rd(8'h03, 8'h01, "R7");
    stat_in = 8'h00;
    wr(8'h03, 8'h0B);
    rd(8'h03, 8'h0B, "R7");
    // R6 live upper bits
    sw_stat = 4'hC;
    rd(8'h03, 8'hCB, "R6");
    wr(8'h03, 8'hF0);
    rd(8'h03, 8'hC0, "R6");
    sw_stat = 0;
    // R8 live pins
    gpio_pins = 3'b101;
    rd(8'h06, 8'hFD, "R8");
    wr(8'h06, 8'h07);
    rd(8'h0E, 8'h05, "R8");
    // R11 ADC port while locked
    @(negedge clk); adc_we = 1; adc_sel = 4'd3; adc_wdata = 8'h99;
    @(negedge clk); adc_we = 0;
    rd(8'h13, 8'h99, "R11");
    @(negedge clk); adc_we = 1; adc_sel = 4'd12; adc_wdata = 8'h6E;
    @(negedge clk); adc_we = 0;
    rd(8'h1C, 8'h6E, "R11");
    // R11 same-cycle conflict, unlocked
    wr(8'h02, 8'h80);
    @(negedge clk); host_addr = 8'h14; host_wdata = 8'h11; host_we = 1;
    adc_we = 1; adc_sel = 4'd4; adc_wdata = 8'h22;
    @(negedge clk); host_we = 0; adc_we = 0;
    rd(8'h14, 8'h22, "R11");
    @(negedge clk); host_addr = 8'h15; host_wdata = 8'h55; host_we = 1;
    adc_we = 1; adc_sel = 4'd4; adc_wdata = 8'h23;
    @(negedge clk); host_we = 0; adc_we = 0;
    rd(8'h15, 8'h55, "R11");
    rd(8'h14, 8'h23, "R11");
    // R9 upper bits zero
    wr(8'h07, 8'hA6);
    rd(8'h07, 8'h06, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule